// File: doc/BRIEF.md
# Dispatch Group Slot Tracker

This block follows how a scheduler packs instructions into fixed-size dispatch groups, with at most one operation offered per clock. Each operation is either a real instruction or an emitted no-op. A real instruction arrives already decoded. It carries a slot-cost class, a record-form bit, a bit that forces it to lead a group, a branch bit, and two hazard bits. One hazard bit marks a load that depends on a store already in the group. The other marks a branch that depends on a count-register write already in the group.

The tracker keeps the number of slots and branches used by the open group. It decides when that group closes and a new one opens. For each accepted instruction it reports two things: whether the scheduler should prefer a different candidate, and how many filler no-ops must precede the instruction. A static mode input selects between two padding schemes. In one, a single no-op that ends the group is available. In the other, the group must be filled with ordinary no-ops.

All outputs are registered. They describe the operation accepted on the previous clock and are zero after a cycle with no operation.

Top module: `dgt_slot_tracker`

## Requirements
- R1: After a synchronous active-high reset, slot_count, branch_count, group_start, prefer_other and noop_count are all 0.
- R2: Cost class encoding on in_cost: 0 costs 1 slot, 1 costs 2 slots, 2 or 3 costs 4 slots. An accepted instruction that neither closes nor restarts the group adds its cost to slot_count and its branch bit to branch_count.
- R3: A class-0 instruction with in_record set costs 2 slots instead of 1. in_record has no effect on classes 1 to 3.
- R4: An instruction must lead a group when its cost is above 1 or in_first is set. If such an instruction arrives with slot_count nonzero and below 5, the old group closes: group_start pulses, slot_count becomes the instruction's cost and branch_count becomes its branch bit.
- R5: prefer_other is 1 exactly for an accepted instruction that must lead a group while slot_count was nonzero.
- R6: An instruction accepted while slot_count is 5 or more closes the group without being counted: slot_count and branch_count become 0 and group_start pulses.
- R7: A branch accepted while the group already holds one branch closes the group without being counted: both counts become 0 and group_start pulses.
- R8: In ordinary padding mode (term_noop_mode=0), a hazardous instruction gets noop_count = 5 - slot_count while slot_count is below 6, and 0 at 6. A non-hazardous instruction gets noop_count 0.
- R9: In terminating mode (term_noop_mode=1), a hazardous instruction with slot_count below 6 gets noop_count 1.
- R10: An instruction is hazardous when in_las is set, or when both in_branch and in_ctr_dep are set. in_ctr_dep on a non-branch creates no hazard.
- R11: An emitted no-op (in_noop=1) closes the group when term_noop_mode is 1 or slot_count is 6, and then both counts become 0 and group_start pulses. Otherwise it adds one slot.
- R12: group_start is a single-cycle pulse. A cycle with in_valid=0 leaves both counts unchanged, and on the following cycle group_start, prefer_other and noop_count are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered this cycle |
| in_noop | input | 1 | The operation is an emitted no-op rather than an instruction |
| in_cost | input | 2 | Slot-cost class of the instruction |
| in_record | input | 1 | Record-form instruction |
| in_first | input | 1 | Class must lead a group regardless of cost |
| in_branch | input | 1 | Instruction is a branch |
| in_las | input | 1 | Load depends on a store in the open group |
| in_ctr_dep | input | 1 | Branch depends on a count-register write in the open group |
| term_noop_mode | input | 1 | A single group-terminating no-op is available |
| prefer_other | output | 1 | Last instruction should have been deferred for another candidate |
| noop_count | output | 4 | Filler no-ops needed before the last instruction |
| group_start | output | 1 | The last operation closed the open group |
| slot_count | output | 3 | Slots used by the open group |
| branch_count | output | 1 | Branches in the open group |

## Verification
The checker watches several properties on every cycle. It keeps slot_count within 6 and branch_count within its limit. It checks that a deferral advice is always paired with a group closure, and that a closure leaves at most four slots in use. It also checks that padding never exceeds five no-ops, and that terminating mode never asks for more than one. The exact arithmetic needs the bench's scenarios: each cost class, the record-form upgrade, every fill level from 0 to 6, and the two padding modes. These scenarios also cover the double-branch closure, the count-register branch hazard, and no-op handling at the full level.

// File: rtl/dgt_pkg.sv
package dgt_pkg;

  typedef enum logic [1:0] {
    COST_ONE  = 2'd0,
    COST_TWO  = 2'd1,
    COST_FOUR = 2'd2,
    COST_WIDE = 2'd3
  } cost_class_e;

  typedef struct packed {
    cost_class_e cls;
    logic        record;
    logic        first;
    logic        branch;
    logic        las;
    logic        ctr_dep;
  } instr_t;

  localparam int COST_W = 3;

endpackage

// File: rtl/dgt_classify.sv
module dgt_classify
  import dgt_pkg::*;
(
  input  instr_t              instr,
  output logic [COST_W-1:0]   cost,
  output logic                must_lead,
  output logic                hazard
);

  always_comb begin
    unique case (instr.cls)
      COST_ONE:  cost = instr.record ? COST_W'(2) : COST_W'(1);
      COST_TWO:  cost = COST_W'(2);
      default:   cost = COST_W'(4);
    endcase
  end

  assign must_lead = (cost != COST_W'(1)) || instr.first;
  assign hazard    = instr.las || (instr.branch && instr.ctr_dep);

endmodule

// File: rtl/dgt_pad_calc.sv
module dgt_pad_calc #(
  parameter int GROUP_SLOTS = 5,
  parameter int NOOP_SLOTS  = 6,
  parameter int SLOT_W      = 3,
  parameter int NOOP_W      = 4
) (
  input  logic [SLOT_W-1:0] slots,
  input  logic              hazard,
  input  logic              term_mode,
  output logic [NOOP_W-1:0] pad
);

  localparam logic [SLOT_W-1:0] PAD_LIMIT = SLOT_W'(NOOP_SLOTS);
  localparam logic [NOOP_W-1:0] PAD_BASE  = NOOP_W'(GROUP_SLOTS);

  logic [NOOP_W-1:0] fill_amount;

  assign fill_amount = PAD_BASE - NOOP_W'(slots);

  always_comb begin
    if (!hazard || slots >= PAD_LIMIT) pad = '0;
    else if (term_mode)                pad = NOOP_W'(1);
    else                               pad = fill_amount;
  end

endmodule

// File: rtl/dgt_group_ctrl.sv
module dgt_group_ctrl
  import dgt_pkg::*;
#(
  parameter int GROUP_SLOTS  = 5,
  parameter int NOOP_SLOTS   = 6,
  parameter int MAX_BRANCHES = 1,
  parameter int SLOT_W       = 3,
  parameter int BR_W         = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic              is_noop,
  input  logic [COST_W-1:0] cost,
  input  logic              must_lead,
  input  logic              is_branch,
  input  logic              term_mode,
  output logic [SLOT_W-1:0] slots,
  output logic [BR_W-1:0]   branches,
  output logic              closed
);

  localparam int SUM_W = SLOT_W + 1;
  localparam logic [SLOT_W-1:0] FULL_AT  = SLOT_W'(GROUP_SLOTS);
  localparam logic [SLOT_W-1:0] NOOP_TOP = SLOT_W'(NOOP_SLOTS);
  localparam logic [BR_W-1:0]   BR_TOP   = BR_W'(MAX_BRANCHES);

  logic [SLOT_W-1:0] slots_d;
  logic [BR_W-1:0]   br_d;
  logic              closed_d;
  logic [SLOT_W-1:0] base_slots;
  logic [BR_W-1:0]   base_br;
  logic [SUM_W-1:0]  slot_sum;

  always_comb begin
    slots_d    = slots;
    br_d       = branches;
    closed_d   = 1'b0;
    base_slots = slots;
    base_br    = branches;
    slot_sum   = '0;
    if (valid) begin
      if (is_noop) begin
        if (term_mode || slots == NOOP_TOP) begin
          slots_d  = '0;
          br_d     = '0;
          closed_d = 1'b1;
        end else begin
          slots_d = slots + SLOT_W'(1);
        end
      end else if (slots >= FULL_AT || (is_branch && branches == BR_TOP)) begin
        slots_d  = '0;
        br_d     = '0;
        closed_d = 1'b1;
      end else begin
        if (must_lead && slots != '0) begin
          base_slots = '0;
          base_br    = '0;
          closed_d   = 1'b1;
        end
        slot_sum = SUM_W'(base_slots) + SUM_W'(cost);
        slots_d  = slot_sum[SLOT_W-1:0];
        br_d     = base_br + BR_W'(is_branch);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      slots    <= '0;
      branches <= '0;
      closed   <= 1'b0;
    end else begin
      slots    <= slots_d;
      branches <= br_d;
      closed   <= closed_d;
    end
  end

endmodule

// File: rtl/dgt_slot_tracker.sv
module dgt_slot_tracker
  import dgt_pkg::*;
#(
  parameter int GROUP_SLOTS  = 5,
  parameter int NOOP_SLOTS   = 6,
  parameter int MAX_BRANCHES = 1,
  parameter int NOOP_W       = 4,
  localparam int SLOT_W      = $clog2(NOOP_SLOTS + 1),
  localparam int BR_W        = $clog2(MAX_BRANCHES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_noop,
  input  logic [1:0]        in_cost,
  input  logic              in_record,
  input  logic              in_first,
  input  logic              in_branch,
  input  logic              in_las,
  input  logic              in_ctr_dep,
  input  logic              term_noop_mode,
  output logic              prefer_other,
  output logic [NOOP_W-1:0] noop_count,
  output logic              group_start,
  output logic [SLOT_W-1:0] slot_count,
  output logic [BR_W-1:0]   branch_count
);

  instr_t            cur;
  logic [COST_W-1:0] cost;
  logic              must_lead;
  logic              hazard;
  logic [NOOP_W-1:0] pad;
  logic              take_instr;

  assign cur.cls     = cost_class_e'(in_cost);
  assign cur.record  = in_record;
  assign cur.first   = in_first;
  assign cur.branch  = in_branch;
  assign cur.las     = in_las;
  assign cur.ctr_dep = in_ctr_dep;

  assign take_instr = in_valid && !in_noop;

  dgt_classify u_classify (
    .instr     (cur),
    .cost      (cost),
    .must_lead (must_lead),
    .hazard    (hazard)
  );

  dgt_pad_calc #(
    .GROUP_SLOTS (GROUP_SLOTS),
    .NOOP_SLOTS  (NOOP_SLOTS),
    .SLOT_W      (SLOT_W),
    .NOOP_W      (NOOP_W)
  ) u_pad (
    .slots     (slot_count),
    .hazard    (hazard),
    .term_mode (term_noop_mode),
    .pad       (pad)
  );

  dgt_group_ctrl #(
    .GROUP_SLOTS  (GROUP_SLOTS),
    .NOOP_SLOTS   (NOOP_SLOTS),
    .MAX_BRANCHES (MAX_BRANCHES),
    .SLOT_W       (SLOT_W),
    .BR_W         (BR_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .valid     (in_valid),
    .is_noop   (in_noop),
    .cost      (cost),
    .must_lead (must_lead),
    .is_branch (in_branch),
    .term_mode (term_noop_mode),
    .slots     (slot_count),
    .branches  (branch_count),
    .closed    (group_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      prefer_other <= 1'b0;
      noop_count   <= '0;
    end else begin
      prefer_other <= take_instr && must_lead && (slot_count != '0);
      noop_count   <= take_instr ? pad : '0;
    end
  end

endmodule

// File: rtl/dgt_slot_tracker_chk.sv
module dgt_slot_tracker_chk #(
  parameter int GROUP_SLOTS  = 5,
  parameter int NOOP_SLOTS   = 6,
  parameter int MAX_BRANCHES = 1,
  parameter int NOOP_W       = 4,
  parameter int SLOT_W       = 3,
  parameter int BR_W         = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              term_noop_mode,
  input logic              prefer_other,
  input logic [NOOP_W-1:0] noop_count,
  input logic              group_start,
  input logic [SLOT_W-1:0] slot_count,
  input logic [BR_W-1:0]   branch_count
);

  assert_slot_bound_R6: assert property (@(posedge clk) disable iff (rst)
    slot_count <= SLOT_W'(NOOP_SLOTS));

  assert_branch_bound_R7: assert property (@(posedge clk) disable iff (rst)
    branch_count <= BR_W'(MAX_BRANCHES));

  assert_prefer_closes_R5: assert property (@(posedge clk) disable iff (rst)
    prefer_other |-> group_start);

  assert_restart_fill_R4: assert property (@(posedge clk) disable iff (rst)
    group_start |-> slot_count <= SLOT_W'(4));

  assert_pad_bound_R8: assert property (@(posedge clk) disable iff (rst)
    noop_count <= NOOP_W'(GROUP_SLOTS));

  assert_term_single_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(term_noop_mode)) |-> noop_count <= NOOP_W'(1));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(in_valid)) |->
      (!group_start && !prefer_other && noop_count == '0 &&
       $stable(slot_count) && $stable(branch_count)));

endmodule

bind dgt_slot_tracker dgt_slot_tracker_chk #(
  .GROUP_SLOTS  (GROUP_SLOTS),
  .NOOP_SLOTS   (NOOP_SLOTS),
  .MAX_BRANCHES (MAX_BRANCHES),
  .NOOP_W       (NOOP_W),
  .SLOT_W       (SLOT_W),
  .BR_W         (BR_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .in_valid       (in_valid),
  .term_noop_mode (term_noop_mode),
  .prefer_other   (prefer_other),
  .noop_count     (noop_count),
  .group_start    (group_start),
  .slot_count     (slot_count),
  .branch_count   (branch_count)
);

// File: tb/dgt_slot_tracker_tb.sv
module dgt_slot_tracker_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0, in_noop = 1'b0;
  logic [1:0] in_cost = 2'd0;
  logic       in_record = 1'b0, in_first = 1'b0, in_branch = 1'b0;
  logic       in_las = 1'b0, in_ctr_dep = 1'b0, term_noop_mode = 1'b0;
  logic       prefer_other, group_start;
  logic [3:0] noop_count;
  logic [2:0] slot_count;
  logic [0:0] branch_count;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dgt_slot_tracker u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_noop(in_noop),
    .in_cost(in_cost), .in_record(in_record), .in_first(in_first),
    .in_branch(in_branch), .in_las(in_las), .in_ctr_dep(in_ctr_dep),
    .term_noop_mode(term_noop_mode), .prefer_other(prefer_other),
    .noop_count(noop_count), .group_start(group_start),
    .slot_count(slot_count), .branch_count(branch_count)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic op(bit v, bit nop, int cls, bit rec, bit fst, bit br, bit las, bit ctr);
    in_valid = v; in_noop = nop; in_cost = 2'(cls); in_record = rec;
    in_first = fst; in_branch = br; in_las = las; in_ctr_dep = ctr;
    cyc();
    in_valid = 1'b0; in_noop = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc();
    rst = 1'b0;
  endtask

  task automatic fill(int s);
    for (int i = 0; i < s; i++) op(1, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic expect_state(string req, int s, int b, int st, int pr, int nc);
    chk({req, " slot_count"}, slot_count, s);
    chk({req, " branch_count"}, branch_count, b);
    chk({req, " group_start"}, group_start, st);
    chk({req, " prefer_other"}, prefer_other, pr);
    chk({req, " noop_count"}, noop_count, nc);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state
    expect_state("R1", 0, 0, 0, 0, 0);

    // R2 R3 R4 R5 R6 R8 R9: sweep over fill level and instruction attributes
    for (int s = 0; s < 6; s++)
      for (int cls = 0; cls < 4; cls++)
        for (int rec = 0; rec < 2; rec++)
          for (int fst = 0; fst < 2; fst++)
            for (int br = 0; br < 2; br++)
              for (int haz = 0; haz < 2; haz++)
                for (int tm = 0; tm < 2; tm++) begin
                  int cost, ms, mb, mst, mpr, mnc;
                  bit lead;
                  term_noop_mode = tm[0];
                  do_reset();
                  fill(s);
                  op(1, 0, cls, rec[0], fst[0], br[0], haz[0], 0);
                  cost = (cls == 0) ? (rec ? 2 : 1) : (cls == 1 ? 2 : 4);
                  lead = (cost > 1) || (fst != 0);
                  mpr  = (lead && s != 0) ? 1 : 0;
                  mnc  = (haz != 0) ? (tm != 0 ? 1 : 5 - s) : 0;
                  if (s >= 5) begin
                    ms = 0; mb = 0; mst = 1;
                  end else if (lead && s != 0) begin
                    ms = cost; mb = br; mst = 1;
                  end else begin
                    ms = s + cost; mb = br; mst = 0;
                  end
                  expect_state("R2/R3/R4/R5/R6/R8/R9 sweep", ms, mb, mst, mpr, mnc);
                end
    term_noop_mode = 1'b0;

    // R7: second branch closes the group
    do_reset();
    op(1, 0, 0, 0, 0, 1, 0, 0);
    expect_state("R7 first branch", 1, 1, 0, 0, 0);
    op(1, 0, 0, 0, 0, 0, 0, 0);
    expect_state("R7 plain after branch", 2, 1, 0, 0, 0);
    op(1, 0, 0, 0, 0, 1, 0, 0);
    expect_state("R7 second branch", 0, 0, 1, 0, 0);
    // R12: idle cycle after a closure
    op(0, 0, 0, 0, 0, 0, 0, 0);
    expect_state("R12 idle", 0, 0, 0, 0, 0);

    // R10: count-register dependent branch vs non-branch
    for (int tm = 0; tm < 2; tm++) begin
      term_noop_mode = tm[0];
      do_reset();
      fill(2);
      op(1, 0, 0, 0, 0, 1, 0, 1);
      chk("R10 ctr branch pad", noop_count, tm != 0 ? 1 : 3);
      op(1, 0, 0, 0, 0, 0, 0, 1);
      chk("R10 ctr non-branch pad", noop_count, 0);
      chk("R10 ctr non-branch slots", slot_count, 4);
    end

    // R11: emitted no-op at every fill level
    for (int s = 0; s < 6; s++)
      for (int tm = 0; tm < 2; tm++) begin
        term_noop_mode = tm[0];
        do_reset();
        fill(s);
        op(1, 1, 0, 0, 0, 0, 0, 0);
        if (tm != 0) expect_state("R11 term noop", 0, 0, 1, 0, 0);
        else         expect_state("R11 plain noop", s + 1, 0, 0, 0, 0);
      end

    // R11 R8 R6: behaviour at the full level of 6
    term_noop_mode = 1'b0;
    do_reset();
    fill(5);
    op(1, 1, 0, 0, 0, 0, 0, 0);
    chk("R11 reach six", slot_count, 6);
    op(1, 0, 0, 0, 0, 0, 1, 0);
    expect_state("R8/R6 hazard at six", 0, 0, 1, 0, 0);
    do_reset();
    fill(5);
    op(1, 1, 0, 0, 0, 0, 0, 0);
    op(1, 1, 0, 0, 0, 0, 0, 0);
    expect_state("R11 noop at six", 0, 0, 1, 0, 0);
    // R12: idle holds counts and clears the pulse
    fill(3);
    op(0, 0, 0, 0, 0, 0, 0, 0);
    expect_state("R12 idle hold", 3, 0, 0, 0, 0);
    op(0, 0, 0, 0, 0, 0, 0, 0);
    expect_state("R12 idle hold again", 3, 0, 0, 0, 0);

    // R1: reset mid-group clears everything
    do_reset();
    expect_state("R1 mid reset", 0, 0, 0, 0, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule